// File: doc/BRIEF.md
# GPIO Edge and Level Interrupt Controller

This block watches a vector of already-synchronized GPIO inputs and turns activity on them into interrupt events. Each pin has three trigger enables: a rising enable, a falling enable and a level-select bit. With the level-select bit clear, the two enables pick edge detection on low-to-high changes, high-to-low changes or both. With the level-select bit set, the same two enables pick the active level instead: the rising enable means active-high and the falling enable means active-low. A pin whose three enables are all clear never raises an event.

Events are latched into sticky status bits that are packed 32 pins to a word. Software reads these words and clears them through a simple 32-bit register port. A write of one clears a bit and a write of zero leaves it alone. A level-triggered pin that is still active sets its bit again straight after a clear, so reading a nonzero word just after an all-ones write shows which pins are still asserting. A single interrupt output is high whenever any status bit is set.

Top module: `gpio_irq_ctrl`

## Requirements
- R1: With the level-select bit clear and the rising enable set, a pin sampled low on one clock and high on the next sets its status bit at that second clock edge.
- R2: With the level-select bit clear and the falling enable set, a pin sampled high then low sets its status bit at the edge where the low value is sampled.
- R3: With the level-select bit clear and both enables set, either direction of change sets the status bit.
- R4: With the level-select bit and the rising enable set, the status bit is set on every clock edge at which the pin is sampled high, so a clear while the pin is still high leaves the bit set.
- R5: With the level-select bit and the falling enable set, the status bit is set on every clock edge at which the pin is sampled low.
- R6: A pin whose rising, falling and level-select bits are all clear never sets its status bit, whatever its input does.
- R7: Pin n occupies bit (n mod 32) of the status word at byte address 0x800 + 4*(n/32). A read request returns the addressed word on rd_data after the next clock edge.
- R8: A write to a status word clears each bit where the write data is 1 and leaves unchanged each bit where it is 0.
- R9: When an event and a clearing write hit the same status bit at the same clock edge, the bit ends up set.
- R10: irq is high exactly when at least one status bit is set; it is low after reset.
- R11: Edge detection compares each input with its value at the previous clock. Enabling an edge trigger on a pin that is steady creates no event, and no edge is reported at the first clock after reset.
- R12: Status bits for pin positions at or above the pin count read as 0, and reads of addresses outside the status words return 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| pin_in | input | NUM_PINS | Synchronized GPIO input levels |
| trig_rise | input | NUM_PINS | Per-pin rising-edge or active-high enable |
| trig_fall | input | NUM_PINS | Per-pin falling-edge or active-low enable |
| trig_lvl | input | NUM_PINS | Per-pin level-select bit |
| req_valid | input | 1 | Register access request this cycle |
| req_write | input | 1 | 1 = write (clear), 0 = read |
| req_addr | input | ADDR_W | Byte address of the access |
| req_wdata | input | 32 | Write data, ones clear bits |
| rd_data | output | 32 | Read data, valid the cycle after a read request |
| irq | output | 1 | Combined interrupt, high while any status bit is set |

## Verification
The hardest situation to reach from the ports is a clear and a fresh event that land on the same status bit at the same clock edge. The bench reaches it in two ways. First, it toggles a both-edge pin on the same half-cycle that it drives the clearing write. Second, it issues an all-ones clear while an active-high level pin is held asserted. It then reads the word back to see that the bit survived.

// File: rtl/gpio_irq_ctrl.sv
module gpio_irq_ctrl #(
  parameter int NUM_PINS  = 64,
  parameter int ADDR_W    = 12,
  parameter int STAT_BASE = 'h800
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NUM_PINS-1:0] pin_in,
  input  logic [NUM_PINS-1:0] trig_rise,
  input  logic [NUM_PINS-1:0] trig_fall,
  input  logic [NUM_PINS-1:0] trig_lvl,
  input  logic                req_valid,
  input  logic                req_write,
  input  logic [ADDR_W-1:0]   req_addr,
  input  logic [31:0]         req_wdata,
  output logic [31:0]         rd_data,
  output logic                irq
);
  localparam int WORDS = (NUM_PINS + 31) / 32;
  localparam int PADW  = WORDS * 32;
  localparam logic [ADDR_W-1:0] BASE_A = ADDR_W'(STAT_BASE);

  logic [NUM_PINS-1:0] prev_in;
  logic                armed;
  logic [NUM_PINS-1:0] rose, fell, ev;
  logic [PADW-1:0]     status, ev_pad, clr;
  logic [ADDR_W-1:0]   offs, widx;
  logic                in_range;

  assign rose = armed ? (pin_in & ~prev_in) : '0;
  assign fell = armed ? (~pin_in & prev_in) : '0;
  assign ev   = (~trig_lvl & ((trig_rise & rose) | (trig_fall & fell)))
              | ( trig_lvl & ((trig_rise & pin_in) | (trig_fall & ~pin_in)));

  assign offs     = req_addr - BASE_A;
  assign widx     = offs >> 2;
  assign in_range = (req_addr >= BASE_A) && (offs[1:0] == 2'b00) &&
                    (widx < ADDR_W'(WORDS));

  always_comb begin
    ev_pad = '0;
    ev_pad[NUM_PINS-1:0] = ev;
    clr = '0;
    for (int w = 0; w < WORDS; w++)
      if (req_valid && req_write && in_range && widx == ADDR_W'(w))
        clr[w*32 +: 32] = req_wdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_in <= '0;
      armed   <= 1'b0;
      status  <= '0;
      rd_data <= '0;
    end else begin
      prev_in <= pin_in;
      armed   <= 1'b1;
      status  <= (status & ~clr) | ev_pad;
      rd_data <= '0;
      for (int w = 0; w < WORDS; w++)
        if (req_valid && !req_write && in_range && widx == ADDR_W'(w))
          rd_data <= status[w*32 +: 32];
    end
  end

  assign irq = |status;

  // A status bit may only become set if an event was seen at that edge.
  assert_no_spurious_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (status[NUM_PINS-1:0] & ~$past(status[NUM_PINS-1:0]) & ~$past(ev)) == '0);

  assert_disabled_pin_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (status[NUM_PINS-1:0] & ~$past(status[NUM_PINS-1:0]) &
     $past(~(trig_rise | trig_fall | trig_lvl))) == '0);

  assert_event_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (ev != '0) |=> ((status[NUM_PINS-1:0] & $past(ev)) == $past(ev)));

  assert_w1c_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (clr != '0) |=> ((status & $past(clr) & ~$past(ev_pad)) == '0));

  assert_irq_drop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(irq) |-> $past(req_valid && req_write));
endmodule

// File: tb/gpio_irq_ctrl_bench.sv
module gpio_irq_ctrl_bench;
  localparam int NP = 40;
  logic clk = 1'b0, rst_n = 1'b0;
  logic [NP-1:0] pin_in = '0, trig_rise = '0, trig_fall = '0, trig_lvl = '0;
  logic req_valid = 1'b0, req_write = 1'b0;
  logic [11:0] req_addr = '0;
  logic [31:0] req_wdata = '0, rd_data;
  logic irq;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  gpio_irq_ctrl #(.NUM_PINS(NP), .ADDR_W(12), .STAT_BASE('h800)) u_gpio_irq_ctrl (
    .clk, .rst_n, .pin_in, .trig_rise, .trig_fall, .trig_lvl,
    .req_valid, .req_write, .req_addr, .req_wdata, .rd_data, .irq);

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(negedge clk); endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    req_valid = 1; req_write = 1; req_addr = a; req_wdata = d;
    tick();
    req_valid = 0; req_write = 0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    req_valid = 1; req_write = 0; req_addr = a;
    tick();
    req_valid = 0;
    d = rd_data;
  endtask

  task automatic clear_all();
    wr(12'h800, '1); wr(12'h804, '1);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    check("R10 irq after reset", 32'(irq), 0);
    rd(12'h800, d); check("R7 word0 after reset", d, 0);
    rd(12'h804, d); check("R7 word1 after reset", d, 0);
  endtask

  task automatic t_rise();
    logic [31:0] d;
    trig_rise[3] = 1; tick(); tick();
    check("R11 enable on steady pin", 32'(irq), 0);
    pin_in[3] = 1; tick();
    check("R10 irq after rise", 32'(irq), 1);
    rd(12'h800, d); check("R1 rising sets bit3", d, 32'h8);
    wr(12'h800, 32'h0); rd(12'h800, d); check("R8 write zero keeps bit", d, 32'h8);
    wr(12'h800, 32'h8); rd(12'h800, d); check("R8 one clears bit", d, 0);
    check("R10 irq low after clear", 32'(irq), 0);
    pin_in[3] = 0; tick(); rd(12'h800, d); check("R1 fall ignored in rise mode", d, 0);
    trig_rise[3] = 0;
  endtask

  task automatic t_fall();
    logic [31:0] d;
    pin_in[5] = 1; tick(); trig_fall[5] = 1; tick();
    rd(12'h800, d); check("R2 rise ignored in fall mode", d, 0);
    pin_in[5] = 0; tick();
    rd(12'h800, d); check("R2 falling sets bit5", d, 32'h20);
    trig_fall[5] = 0; clear_all();
  endtask

  task automatic t_both();
    logic [31:0] d;
    trig_rise[7] = 1; trig_fall[7] = 1; tick();
    pin_in[7] = 1; tick();
    rd(12'h800, d); check("R3 both mode rise", d, 32'h80);
    wr(12'h800, 32'h80);
    pin_in[7] = 0; tick();
    rd(12'h800, d); check("R3 both mode fall", d, 32'h80);
    wr(12'h800, 32'h80); rd(12'h800, d); check("R8 cleared", d, 0);
    pin_in[7] = 1;
    wr(12'h800, 32'h80);
    rd(12'h800, d); check("R9 event wins over same-edge clear", d, 32'h80);
    trig_rise[7] = 0; trig_fall[7] = 0; clear_all();
  endtask

  task automatic t_level();
    logic [31:0] d;
    pin_in[33] = 1; tick();
    trig_lvl[33] = 1; trig_rise[33] = 1; tick();
    rd(12'h804, d); check("R4 level high pin33 word1 bit1", d, 32'h2);
    wr(12'h804, '1);
    rd(12'h804, d); check("R4 reasserts after clear while active", d, 32'h2);
    pin_in[33] = 0; tick(); wr(12'h804, '1);
    rd(12'h804, d); check("R4 clear after release", d, 0);
    trig_lvl[33] = 0; trig_rise[33] = 0;
    trig_lvl[34] = 1; trig_fall[34] = 1; tick();
    rd(12'h804, d); check("R5 level low pin34 word1 bit2", d, 32'h4);
    pin_in[34] = 1; tick(); wr(12'h804, 32'h4);
    rd(12'h804, d); check("R5 inactive level stays clear", d, 0);
    trig_lvl[34] = 0; trig_fall[34] = 0; clear_all();
  endtask

  task automatic t_disabled();
    logic [31:0] d;
    for (int i = 0; i < 6; i++) begin pin_in[10] = ~pin_in[10]; tick(); end
    rd(12'h800, d); check("R6 disabled pin never sets", d, 0);
    check("R6 irq stays low", 32'(irq), 0);
  endtask

  task automatic t_range();
    logic [31:0] d;
    trig_lvl = '1; trig_rise = '1; pin_in = '1; tick();
    rd(12'h804, d); check("R12 bits above pin count zero", d, 32'h0000_00FF);
    rd(12'h800, d); check("R7 all word0 pins set", d, 32'hFFFF_FFFF);
    rd(12'h808, d); check("R12 address past words reads zero", d, 0);
    rd(12'h802, d); check("R12 unaligned address reads zero", d, 0);
    trig_lvl = '0; trig_rise = '0; tick(); clear_all();
    check("R10 irq low at end", 32'(irq), 0);
  endtask

  initial begin
    fork
      begin
        repeat (3) tick();
        rst_n = 1;
        pin_in[20] = 1; trig_rise[20] = 1; tick();
        check("R11 no edge at first clock after reset", 32'(irq), 0);
        trig_rise[20] = 0; pin_in[20] = 0; tick();
        t_reset(); t_rise(); t_fall(); t_both(); t_level(); t_disabled(); t_range();
      end
      begin
        repeat (5000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
      end
    join_any
    disable fork;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule